// File: doc/BRIEF.md
# Request-Gated Serial Log Transmitter

This block sends 32-bit log words to a slower receiver over a four-wire serial link, using clock mode 0 with the most significant bit first. A producer loads a word with a one-cycle strobe. The block then holds the word until the receiver signals that it is ready by raising a request line.

When the block sees the request, it waits one half-period and pulls chip select low. It then shifts the word out. For each bit it updates the data line, raises the serial clock for one half-period and lowers it for one half-period. After the last bit it releases chip select and pulses a completion flag.

The receiver drops its request as soon as it sees chip select fall, so no second word can start until it asks again. The half-period is a parameter counted in system clocks. Its default is one eighth of a millisecond at a 50 MHz system clock.

Top module: `spi_log_tx`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, cs_n is 1, and sclk, mosi, busy and done are 0.
- R2: A load strobe while idle captures load_data and raises busy on the next cycle. While req stays low after that, cs_n stays 1 and sclk and mosi stay 0.
- R3: The clock edge that samples req high starts the transfer, and cs_n falls exactly HALF_CYC clock edges later.
- R4: Exactly 32 bits are sent on mosi, bit 31 of the captured word first and bit 0 last.
- R5: Each bit is placed on mosi one cycle before sclk rises. sclk then stays high for HALF_CYC cycles and low for HALF_CYC cycles.
- R6: mosi does not change while sclk is high, nor on the cycle in which sclk falls.
- R7: On the cycle after the 32nd low phase ends, cs_n returns to 1, mosi to 0 and busy to 0, and done is 1 for that single cycle.
- R8: A load strobe while busy is 1 is ignored. The word in flight is unchanged, and no further transfer is queued.
- R9: sclk is never 1 while cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe that captures load_data when idle |
| load_data | input | WORD_W | Log word to send |
| req | input | 1 | Receiver ready, active high |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the receiver |
| busy | output | 1 | High from word capture until the transfer completes |
| done | output | 1 | One-cycle pulse when chip select is released |

## Verification
The assertions assume that load, load_data and req are synchronous to clk. They also assume that reset is applied before the first transfer, so the high-phase length counter starts from a known zero.

The bench drives every input on the falling edge of the clock. Its receiver model only raises req while no frame is active and drops it once it sees chip select low. A load pulse is therefore the only input that can arrive mid-frame, and that is the case R8 covers.

// File: rtl/spi_log_pkg.sv
package spi_log_pkg;

    // System clocks in one eighth of a millisecond.
    function automatic int cycles_per_half(input int clk_hz);
        return clk_hz / 8000;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_SETUP,
        ST_HIGH,
        ST_LOW
    } tx_state_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic mosi;
    } line_set_t;

    localparam line_set_t LINES_QUIET = '{cs_n: 1'b1, sclk: 1'b0, mosi: 1'b0};

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF_CYC = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    localparam int EFF_HALF = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int CNT_W    = $clog2(EFF_HALF + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CNT_W'(EFF_HALF - 1));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] word_in,
    input  logic              take,
    output logic              head,
    output logic              all_taken
);
    localparam int TAKE_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh;
    logic [TAKE_W-1:0] taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            taken <= '0;
        end else if (capture) begin
            sh    <= word_in;
            taken <= '0;
        end else if (take) begin
            sh    <= sh << 1;
            taken <= taken + 1'b1;
        end
    end

    assign head      = sh[WORD_W-1];
    assign all_taken = (taken == TAKE_W'(WORD_W));

endmodule

// File: rtl/spi_log_ctrl.sv
module spi_log_ctrl
    import spi_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      req,
    input  logic      tmr_done,
    input  logic      head,
    input  logic      all_taken,
    output logic      accept,
    output logic      take,
    output logic      tmr_clr,
    output line_set_t lines,
    output logic      busy,
    output logic      done
);
    tx_state_t state;
    logic      timed;

    always_comb begin
        accept  = (state == ST_IDLE) && load;
        timed   = (state == ST_LEAD) || (state == ST_HIGH) || (state == ST_LOW);
        tmr_clr = !timed || tmr_done;
        take    = ((state == ST_LEAD) && tmr_done) ||
                  ((state == ST_LOW) && tmr_done && !all_taken);
        busy    = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            lines <= LINES_QUIET;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (req) state <= ST_LEAD;
                end
                ST_LEAD: begin
                    if (tmr_done) begin
                        lines.cs_n <= 1'b0;
                        lines.mosi <= head;
                        state      <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    lines.sclk <= 1'b1;
                    state      <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tmr_done) begin
                        lines.sclk <= 1'b0;
                        state      <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tmr_done) begin
                        if (all_taken) begin
                            lines <= LINES_QUIET;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            lines.mosi <= head;
                            state      <= ST_SETUP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_log_tx.sv
module spi_log_tx
    import spi_log_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = cycles_per_half(50_000_000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              req,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done
);
    logic      accept;
    logic      take;
    logic      tmr_clr;
    logic      tmr_done;
    logic      head;
    logic      all_taken;
    line_set_t lines;

    spi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .expired (tmr_done)
    );

    spi_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .capture   (accept),
        .word_in   (load_data),
        .take      (take),
        .head      (head),
        .all_taken (all_taken)
    );

    spi_log_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .req       (req),
        .tmr_done  (tmr_done),
        .head      (head),
        .all_taken (all_taken),
        .accept    (accept),
        .take      (take),
        .tmr_clr   (tmr_clr),
        .lines     (lines),
        .busy      (busy),
        .done      (done)
    );

    assign cs_n = lines.cs_n;
    assign sclk = lines.sclk;
    assign mosi = lines.mosi;

endmodule

// File: rtl/spi_log_tx_chk.sv
module spi_log_tx_chk #(
    parameter int HALF_CYC = 6250
) (
    input logic clk,
    input logic rst,
    input logic load,
    input logic req,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic done
);
    logic [31:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst) hi_len <= '0;
        else if (sclk) hi_len <= hi_len + 32'd1;
        else hi_len <= '0;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && !sclk && !mosi));

    // R3
    select_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> busy);

    // R5
    data_before_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));

    // R5
    high_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_len == 32'(HALF_CYC)));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |=> $stable(mosi));

    // R7
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (done && !busy));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    clock_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !cs_n) |=> !cs_n || done);

    // R2
    req_observed_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cs_n && !req && !sclk) |=> cs_n);

endmodule

bind spi_log_tx spi_log_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .req  (req),
    .cs_n (cs_n),
    .sclk (sclk),
    .mosi (mosi),
    .busy (busy),
    .done (done)
);

// File: tb/sim_spi_log_tx.sv
module sim_spi_log_tx;
    localparam int H    = 3;
    localparam int BITW = 32;
    localparam int SLOT = 2 * H + 1;
    localparam int LAST = H + BITW * SLOT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] load_data = '0;
    logic        req = 1'b0;
    logic        cs_n, sclk, mosi, busy, done;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spi_log_tx #(.WORD_W(BITW), .HALF_CYC(H)) u0 (
        .clk(clk), .rst(rst), .load(load), .load_data(load_data), .req(req),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: frame position counted from the edge that sees req.
    bit          pending = 0, running = 0, started = 0;
    int          k = 0;
    logic [31:0] word = '0;
    logic        e_cs = 1, e_sclk = 0, e_mosi = 0, e_busy = 0, e_done = 0;

    always @(posedge clk) begin
        started = 1;
        e_done  = 0;
        if (rst) begin
            pending = 0;
            running = 0;
        end else if (running) begin
            k = k + 1;
            if (k == LAST) begin
                running = 0;
                e_done  = 1;
            end
        end else if (pending) begin
            if (req) begin
                pending = 0;
                running = 1;
                k       = 0;
            end
        end else if (load) begin
            pending = 1;
            word    = load_data;
        end
        e_busy = pending || running;
        e_cs = 1; e_sclk = 0; e_mosi = 0;
        if (running && k >= H) begin
            e_cs   = 0;
            e_mosi = word[BITW - 1 - (k - H) / SLOT];
            e_sclk = (((k - H) % SLOT) >= 1) && (((k - H) % SLOT) <= H);
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(cs_n === e_cs, "R3 cs_n", 32'(cs_n), 32'(e_cs));
            chk(sclk === e_sclk, "R5 sclk", 32'(sclk), 32'(e_sclk));
            chk(mosi === e_mosi, "R4/R6 mosi", 32'(mosi), 32'(e_mosi));
            chk(busy === e_busy, "R2/R8 busy", 32'(busy), 32'(e_busy));
            chk(done === e_done, "R7 done", 32'(done), 32'(e_done));
        end
    end

    // Receiver model: samples on rising sclk, drops req when cs_n falls.
    int          raise_tok = 0, raise_seen = 0, got_cnt = 0;
    logic [31:0] rx = '0, got = '0;
    logic        p_cs = 1, p_sclk = 0;

    always @(negedge clk) begin
        if (raise_tok != raise_seen) begin
            raise_seen = raise_tok;
            req = 1;
        end
        if (p_cs && !cs_n) begin
            req = 0;
            rx  = '0;
        end
        if (!p_sclk && sclk) rx = {rx[30:0], mosi};
        if (!p_cs && cs_n) begin
            got = rx;
            got_cnt++;
        end
        p_cs   = cs_n;
        p_sclk = sclk;
    end

    task automatic pulse_load(input logic [31:0] d);
        @(negedge clk);
        load = 1; load_data = d;
        @(negedge clk);
        load = 0;
    endtask

    task automatic wait_rx(input int n);
        while (got_cnt < n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1
        repeat (3) @(negedge clk);
        chk(cs_n === 1 && sclk === 0 && mosi === 0 && busy === 0 && done === 0,
            "R1 reset lines", {27'b0, cs_n, sclk, mosi, busy, done}, 32'h10);
        rst = 0;
        @(negedge clk);
        chk(cs_n === 1 && sclk === 0 && mosi === 0 && busy === 0,
            "R1 after release", {28'b0, cs_n, sclk, mosi, busy}, 32'h8);

        // R2: load, hold req low for a while
        pulse_load(32'hA5C3_0F81);
        chk(busy === 1, "R2 busy after load", 32'(busy), 32'h1);
        repeat (20) @(negedge clk);
        chk(cs_n === 1 && sclk === 0, "R2 blocked without req",
            {30'b0, cs_n, sclk}, 32'h2);
        raise_tok++;
        wait_rx(1);
        chk(got === 32'hA5C3_0F81, "R4 word 1", got, 32'hA5C3_0F81);
        chk(req === 0, "R3 req dropped by receiver", 32'(req), 32'h0);

        // req already high before load; load again during the frame (R8)
        raise_tok++;
        repeat (3) @(negedge clk);
        pulse_load(32'h8000_0001);
        while (cs_n) @(negedge clk);
        repeat (10) @(negedge clk);
        pulse_load(32'hFFFF_FFFF);
        wait_rx(2);
        chk(got === 32'h8000_0001, "R8 word unchanged", got, 32'h8000_0001);
        raise_tok++;
        repeat (30) @(negedge clk);
        chk(busy === 0 && cs_n === 1, "R8 nothing queued",
            {30'b0, busy, cs_n}, 32'h1);

        // req still high: all-ones word, then all-zeros word
        pulse_load(32'hFFFF_FFFF);
        wait_rx(3);
        chk(got === 32'hFFFF_FFFF, "R4 all ones", got, 32'hFFFF_FFFF);
        raise_tok++;
        pulse_load(32'h0000_0000);
        wait_rx(4);
        chk(got === 32'h0, "R4 all zeros", got, 32'h0);
        raise_tok++;
        pulse_load(32'h1357_9BDF);
        wait_rx(5);
        chk(got === 32'h1357_9BDF, "R4 word 5", got, 32'h1357_9BDF);
        repeat (5) @(negedge clk);
        chk(busy === 0 && cs_n === 1 && mosi === 0, "R7 idle after frame",
            {29'b0, busy, cs_n, mosi}, 32'h2);
        finish_run();
    end

endmodule